// File: doc/BRIEF.md
# DDR3 Refresh Burst Scheduler

This block decides when a DDR3 memory controller refreshes its device. It stays idle until the power-up sequence reports completion. After that it counts clocks since the most recent REFRESH. When enough time has passed, it asks the command arbiter for the bus. Once the arbiter grants it, the block issues a burst of several REFRESH commands back to back. Consecutive commands in a burst are exactly one refresh cycle time apart. A busy flag holds the arbiter at NOP for the whole burst and for one refresh cycle time after the last command.

Because the refreshes are batched, the allowed gap between bursts is the nominal interval multiplied by the burst length, minus the recovery time already spent inside the burst. With the default parameters the gap is 4·1560 − 3·320 = 5280 clocks. The request goes out a configurable lead time before that deadline. This leaves the arbiter time to finish any open access and precharge every bank before it grants. Closing banks is the arbiter's job, not this block's.

The controller has five states:
- IDLE waits for `init_done`.
- WAIT counts the interval.
- REQ holds the request until a grant arrives.
- ISSUE drives one REFRESH.
- GAP waits out the refresh cycle time.

The transitions are:
- IDLE→WAIT when `init_done` is sampled high.
- WAIT→REQ when the interval counter reaches the request point.
- REQ→ISSUE when `grant` is sampled high.
- ISSUE→GAP always, one cycle later.
- GAP→ISSUE when the refresh cycle time has elapsed and the burst is not yet complete.
- GAP→WAIT when the refresh cycle time has elapsed and the burst is complete.

Top module: `rfsh_burst_sched`

## Requirements
- R1: After reset, `ref_req`, `ref_cmd` and `ref_busy` are all low. They stay low for as long as `init_done` is low.
- R2: The interval counter starts on the clock edge that first samples `init_done` high. On the (DEADLINE−LEAD+1)-th rising edge, counting that edge as the first, `ref_req` goes high. DEADLINE is BURST·T_REFI − (BURST−1)·T_RFC. With the defaults, DEADLINE is 5280 and the edge is the 5181st.
- R3: `ref_req` stays high for as long as `grant` is sampled low. On the cycle after `grant` is sampled high during a request, `ref_cmd` is high for exactly one cycle (a high `ref_cmd` means a REFRESH command) and `ref_req` is low.
- R4: Each granted request produces exactly BURST `ref_cmd` pulses. Consecutive pulses are exactly T_RFC clocks apart. `ref_req` stays low throughout the burst.
- R5: `ref_busy` is high from the cycle of the first pulse of a burst through the T_RFC−1 cycles that follow the last pulse. That makes BURST·T_RFC cycles in all. `ref_busy` is low T_RFC cycles after the last pulse.
- R6: `ref_req` rises exactly DEADLINE−LEAD clocks after the last pulse of the previous burst. With an immediate grant, the next burst's first pulse therefore lands at most DEADLINE clocks after the last one.
- R7: `grant` has no effect while `ref_req` is low: it produces no `ref_cmd` while idle, while counting the interval, or during a burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_done | input | 1 | Device initialization sequence has completed |
| grant | input | 1 | Arbiter hands the command bus to the scheduler |
| ref_req | output | 1 | Request for the command bus (banks must be closed before grant) |
| ref_cmd | output | 1 | One-cycle strobe: issue REFRESH this cycle |
| ref_busy | output | 1 | Burst in progress; arbiter must drive only NOP |

## Verification
The assertions assume that the arbiter answers a request within LEAD−1 clocks. If it does, the first REFRESH of every burst arrives within DEADLINE clocks of the previous burst's last one. The deadline assertion depends on this assumption. The stimulus respects it: the longest grant delay it applies is 20 clocks, well inside the lead time of 100. Outside a request, the stimulus may drive `grant` high at any time, including for an entire burst, because the design must ignore it there.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_REQ,
        ST_ISSUE,
        ST_GAP
    } rfsh_state_e;

endpackage

// File: rtl/rfsh_since_ctr.sv
// Clocks-since-last-refresh counter: held at zero before start, loaded with
// one on the REFRESH cycle, otherwise counts up and saturates.
module rfsh_since_ctr #(
    parameter int CW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          load_i,
    output logic [CW-1:0] cnt_o
);

    localparam logic [CW-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (clear_i) begin
            cnt_o <= '0;
        end else if (load_i) begin
            cnt_o <= CW'(1);
        end else if (cnt_o != CNT_MAX) begin
            cnt_o <= cnt_o + CW'(1);
        end
    end

endmodule

// File: rtl/rfsh_burst_ctr.sv
// Counts REFRESH commands issued within the current burst.
module rfsh_burst_ctr #(
    parameter int BURST = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic done_o
);

    localparam int BW = $clog2(BURST + 1);

    logic [BW-1:0] issued_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issued_q <= '0;
        end else if (clr_i) begin
            issued_q <= '0;
        end else if (inc_i) begin
            issued_q <= issued_q + BW'(1);
        end
    end

    assign done_o = (issued_q == BW'(BURST));

endmodule

// File: rtl/rfsh_fsm.sv
module rfsh_fsm
    import rfsh_pkg::*;
#(
    parameter int CW     = 14,
    parameter int REQ_AT = 5180,
    parameter int T_RFC  = 320
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init_done,
    input  logic          grant,
    input  logic [CW-1:0] since_i,
    input  logic          burst_done_i,
    output logic          ref_req,
    output logic          ref_cmd,
    output logic          ref_busy,
    output logic          ctr_clear_o,
    output logic          ctr_load_o,
    output logic          burst_clr_o,
    output logic          burst_inc_o
);

    localparam logic [CW-1:0] REQ_POINT = CW'(REQ_AT - 1);
    localparam logic [CW-1:0] GAP_POINT = CW'(T_RFC - 1);

    rfsh_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (init_done) state_d = ST_WAIT;
            ST_WAIT:  if (since_i >= REQ_POINT) state_d = ST_REQ;
            ST_REQ:   if (grant) state_d = ST_ISSUE;
            ST_ISSUE: state_d = ST_GAP;
            ST_GAP: begin
                if (since_i >= GAP_POINT) begin
                    state_d = burst_done_i ? ST_WAIT : ST_ISSUE;
                end
            end
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ref_req     = 1'b0;
        ref_cmd     = 1'b0;
        ref_busy    = 1'b0;
        ctr_clear_o = 1'b0;
        ctr_load_o  = 1'b0;
        burst_clr_o = 1'b0;
        burst_inc_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                ctr_clear_o = 1'b1;
                burst_clr_o = 1'b1;
            end
            ST_WAIT: begin
                burst_clr_o = 1'b1;
            end
            ST_REQ: begin
                ref_req = 1'b1;
            end
            ST_ISSUE: begin
                ref_cmd     = 1'b1;
                ref_busy    = 1'b1;
                ctr_load_o  = 1'b1;
                burst_inc_o = 1'b1;
            end
            ST_GAP: begin
                ref_busy = 1'b1;
            end
            default: begin
                ctr_clear_o = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/rfsh_burst_sched.sv
module rfsh_burst_sched #(
    parameter int T_RFC  = 320,
    parameter int T_REFI = 1560,
    parameter int BURST  = 4,
    parameter int LEAD   = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic init_done,
    input  logic grant,
    output logic ref_req,
    output logic ref_cmd,
    output logic ref_busy
);

    localparam int DEADLINE = BURST * T_REFI - (BURST - 1) * T_RFC;
    localparam int REQ_AT   = DEADLINE - LEAD;
    localparam int CW       = $clog2(DEADLINE + 1) + 1;

    logic [CW-1:0] since_q;
    logic          ctr_clear;
    logic          ctr_load;
    logic          burst_clr;
    logic          burst_inc;
    logic          burst_done;

    rfsh_since_ctr #(.CW(CW)) u_since (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (ctr_clear),
        .load_i  (ctr_load),
        .cnt_o   (since_q)
    );

    rfsh_burst_ctr #(.BURST(BURST)) u_burst (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (burst_clr),
        .inc_i  (burst_inc),
        .done_o (burst_done)
    );

    rfsh_fsm #(.CW(CW), .REQ_AT(REQ_AT), .T_RFC(T_RFC)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .init_done    (init_done),
        .grant        (grant),
        .since_i      (since_q),
        .burst_done_i (burst_done),
        .ref_req      (ref_req),
        .ref_cmd      (ref_cmd),
        .ref_busy     (ref_busy),
        .ctr_clear_o  (ctr_clear),
        .ctr_load_o   (ctr_load),
        .burst_clr_o  (burst_clr),
        .burst_inc_o  (burst_inc)
    );

endmodule

// File: rtl/rfsh_burst_sched_chk.sv
module rfsh_burst_sched_chk #(
    parameter int CW       = 14,
    parameter int DEADLINE = 5280,
    parameter int T_RFC    = 320
) (
    input logic          clk,
    input logic          rst_n,
    input logic          grant,
    input logic          ref_req,
    input logic          ref_cmd,
    input logic          ref_busy,
    input logic [CW-1:0] since_q
);

    // R3
    cmd_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_cmd |=> !ref_cmd);

    // R3
    grant_to_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && grant) |=> (ref_cmd && !ref_req));

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && !grant) |=> ref_req);

    // R4
    no_req_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_busy |-> !ref_req);

    // R5
    busy_covers_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_cmd |-> ref_busy);

    // R4
    burst_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_cmd && $past(ref_busy)) |-> (since_q == CW'(T_RFC)));

    // R6
    burst_deadline_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_cmd && !$past(ref_busy)) |-> (since_q <= CW'(DEADLINE)));

    // R7
    stray_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ref_req && !ref_busy) |=> !ref_cmd);

endmodule

bind rfsh_burst_sched rfsh_burst_sched_chk #(
    .CW       (CW),
    .DEADLINE (DEADLINE),
    .T_RFC    (T_RFC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .grant    (grant),
    .ref_req  (ref_req),
    .ref_cmd  (ref_cmd),
    .ref_busy (ref_busy),
    .since_q  (since_q)
);

// File: tb/rfsh_burst_sched_test.sv
module rfsh_burst_sched_test;

    localparam int RFC      = 320;
    localparam int REFI     = 1560;
    localparam int NBURST   = 4;
    localparam int LEAD     = 100;
    localparam int DEADLINE = NBURST * REFI - (NBURST - 1) * RFC;
    localparam int REQ_AT   = DEADLINE - LEAD;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic init_done = 1'b0;
    logic grant = 1'b0;
    logic ref_req, ref_cmd, ref_busy;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    rfsh_burst_sched #(.T_RFC(RFC), .T_REFI(REFI), .BURST(NBURST), .LEAD(LEAD)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .init_done (init_done),
        .grant     (grant),
        .ref_req   (ref_req),
        .ref_cmd   (ref_cmd),
        .ref_busy  (ref_busy)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic t_reset();
        int highs = 0;
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        check({ref_req, ref_cmd, ref_busy} == 3'b000, "R1 outputs in reset",
              int'({ref_req, ref_cmd, ref_busy}), 0);
        rst_n = 1'b1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            grant = (i % 3) == 0;
            if (ref_req || ref_busy) highs++;
        end
        grant = 1'b0;
        check(highs == 0, "R1 idle while init_done low", highs, 0);
    endtask

    task automatic t_stray_grant_idle();
        int cmds = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            grant = 1'b1;
            if (ref_cmd) cmds++;
        end
        grant = 1'b0;
        check(cmds == 0, "R7 grant ignored before start", cmds, 0);
    endtask

    task automatic t_first_request();
        int n = 0;
        init_done = 1'b1;
        do begin
            @(negedge clk);
            n++;
        end while (!ref_req && n < 20000);
        check(n == REQ_AT + 1, "R2 first request edge", n, REQ_AT + 1);
    endtask

    task automatic t_grant_wait();
        int drops = 0;
        int cmds = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (!ref_req) drops++;
            if (ref_cmd) cmds++;
        end
        check(drops == 0, "R3 request held without grant", drops, 0);
        check(cmds == 0, "R3 no refresh without grant", cmds, 0);
        grant = 1'b1;
        @(negedge clk);
        grant = 1'b0;
        check(ref_cmd == 1'b1, "R3 refresh after grant", int'(ref_cmd), 1);
        check(ref_req == 1'b0, "R3 request dropped after grant", int'(ref_req), 0);
    endtask

    task automatic t_burst(input bit hold_grant, input string name, output int tail);
        int pulses = 1;
        int busy_cnt = 1;
        int last = 0;
        int bad_gap = 0;
        int reqs = 0;
        localparam int WIN = NBURST * RFC + 4;
        grant = hold_grant;
        for (int j = 1; j <= WIN; j++) begin
            @(negedge clk);
            if (ref_cmd) begin
                if (j - last != RFC) bad_gap++;
                pulses++;
                last = j;
            end
            if (ref_busy) busy_cnt++;
            if (ref_req) reqs++;
            if (j == NBURST * RFC)
                check(ref_busy == 1'b0, {"R5 busy low after recovery ", name}, int'(ref_busy), 0);
        end
        grant = 1'b0;
        check(pulses == NBURST, {"R4 pulses per burst ", name}, pulses, NBURST);
        check(bad_gap == 0, {"R4 pulse spacing ", name}, bad_gap, 0);
        check(busy_cnt == NBURST * RFC, {"R5 busy length ", name}, busy_cnt, NBURST * RFC);
        check(reqs == 0, {"R4 no request in burst ", name}, reqs, 0);
        if (hold_grant)
            check(pulses == NBURST, "R7 held grant adds no refresh", pulses, NBURST);
        tail = WIN - last;
    endtask

    task automatic t_next_interval(input int tail);
        int n = tail;
        while (!ref_req && n < 20000) begin
            @(negedge clk);
            n++;
        end
        check(n == REQ_AT, "R6 request after last refresh", n, REQ_AT);
        grant = 1'b1;
        @(negedge clk);
        grant = 1'b0;
        n++;
        check(ref_cmd == 1'b1, "R3 prompt grant gives refresh", int'(ref_cmd), 1);
        check(n <= DEADLINE, "R6 burst gap within deadline", n, DEADLINE);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int tail;
        t_reset();
        t_stray_grant_idle();
        t_first_request();
        t_grant_wait();
        t_burst(1'b0, "first", tail);
        t_next_interval(tail);
        t_burst(1'b1, "held-grant", tail);
        t_next_interval(tail);
        t_burst(1'b0, "third", tail);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule